// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block watches the instruction slots of a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory, writeback. It tracks the destination register, the register-write enable, the load flag and the store flag of each instruction as it moves from decode to writeback. From this state it produces operand bypass selects for the instruction in execute. It also stalls a load's immediate consumer for one cycle, and it holds fetch for a fixed number of cycles after a branch leaves decode.

The register file sits inside the block. Writeback writes it, and a same-cycle read of the register being written returns the new value, so no bypass path from writeback is needed. The surrounding datapath supplies the decode-stage fields and the writeback result. It uses the select codes for the ALU operand multiplexers. When `stall_fd` is high it holds its fetch and decode registers, and while `fetch_hold` is high it stops fetching.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the instruction in the execute/memory slot writes a nonzero register that equals a source of the execute instruction, that operand's select is 2'b10.
- R2: Otherwise, when the memory/writeback slot writes a nonzero register equal to that source, the select is 2'b01. In all other cases it is 2'b00, which means the register file value.
- R3: When both later slots write the same source register, the execute/memory slot wins and the select is 2'b10.
- R4: Register 0 never produces a nonzero select and never causes a stall, even when a slot writes it or a load targets it.
- R5: When execute holds a load whose nonzero destination equals the decode instruction's first or second source, `stall_fd` and `bubble_ex` are high in that cycle. They stay high for exactly one cycle while decode is held.
- R6: A slot inserted by a stall or a branch hold reaches execute with `ex_regwrite` and `ex_memwrite` both low.
- R7: `rf_rdata1` and `rf_rdata2` return the writeback result when the register read is the one being written back in the same cycle. Otherwise they return the stored value, and a later write to a register replaces an earlier one.
- R8: A branch accepted from decode raises `fetch_hold` for exactly 3 cycles (`BR_STALL`), starting the next cycle. Decode instructions offered during the hold are discarded, and `bubble_ex` is high for those cycles.
- R9: After reset all slots are empty, every register reads zero, and `stall_fd`, `bubble_ex`, `fetch_hold`, `ex_regwrite` and `ex_memwrite` are low.
- R10: Register 0 always reads zero, and writebacks to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_rs1 | input | 5 | First source register in decode |
| dec_rs2 | input | 5 | Second source register in decode |
| dec_rd | input | 5 | Destination register in decode |
| dec_regwrite | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction reads data memory |
| dec_store | input | 1 | Decode instruction writes data memory |
| dec_branch | input | 1 | Decode instruction is a branch |
| wb_result | input | 32 | Result of the instruction in writeback |
| fwd_a | output | 2 | Select for ALU operand A in execute |
| fwd_b | output | 2 | Select for ALU operand B in execute |
| stall_fd | output | 1 | Hold fetch and decode registers |
| bubble_ex | output | 1 | Empty slot enters execute next cycle |
| fetch_hold | output | 1 | Branch wait: fetch stopped |
| ex_regwrite | output | 1 | Execute slot writes a register |
| ex_memwrite | output | 1 | Execute slot writes data memory |
| rf_rdata1 | output | 32 | Register file read of dec_rs1 |
| rf_rdata2 | output | 32 | Register file read of dec_rs2 |

## Verification
The checks assume the datapath obeys `stall_fd`: it presents the same decode instruction again in the cycle after a stall. The stimulus always repeats the stalled instruction unchanged. The checks also assume that a branch is never offered while the block is already holding fetch. The stimulus marks decode as empty or as discarded filler during a hold and never places a branch there. Source fields of empty slots are driven as register 0, so an idle slot cannot look like a consumer.

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int XLEN     = 32,
  parameter int NREGS    = 32,
  parameter int BR_STALL = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic [$clog2(NREGS)-1:0] dec_rs1,
  input  logic [$clog2(NREGS)-1:0] dec_rs2,
  input  logic [$clog2(NREGS)-1:0] dec_rd,
  input  logic                     dec_regwrite,
  input  logic                     dec_load,
  input  logic                     dec_store,
  input  logic                     dec_branch,
  input  logic [XLEN-1:0]          wb_result,
  output logic [1:0]               fwd_a,
  output logic [1:0]               fwd_b,
  output logic                     stall_fd,
  output logic                     bubble_ex,
  output logic                     fetch_hold,
  output logic                     ex_regwrite,
  output logic                     ex_memwrite,
  output logic [XLEN-1:0]          rf_rdata1,
  output logic [XLEN-1:0]          rf_rdata2
);
  localparam int RW = $clog2(NREGS);
  localparam int CW = $clog2(BR_STALL + 1);

  logic [RW-1:0] ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_we, ex_ld, ex_st, mem_we, wb_we;
  logic [CW-1:0] br_cnt;
  logic [XLEN-1:0] regs [NREGS];

  logic dec_live, load_use, take, rf_wr;

  assign fetch_hold = br_cnt != '0;
  assign dec_live   = dec_valid && !fetch_hold;
  assign load_use   = dec_live && ex_ld && (ex_rd != '0) &&
                      ((ex_rd == dec_rs1) || (ex_rd == dec_rs2));
  assign take       = dec_live && !load_use;
  assign stall_fd   = load_use;
  assign bubble_ex  = load_use || fetch_hold;
  assign ex_regwrite = ex_we;
  assign ex_memwrite = ex_st;
  assign rf_wr      = wb_we && (wb_rd != '0);

  function automatic logic [1:0] pick(input logic [RW-1:0] rs);
    if (rs == '0)                    return 2'b00;
    else if (mem_we && mem_rd == rs) return 2'b10;
    else if (wb_we && wb_rd == rs)   return 2'b01;
    else                             return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] rd_port(input logic [RW-1:0] rs);
    if (rs == '0)                   return '0;
    else if (rf_wr && wb_rd == rs)  return wb_result;
    else                            return regs[rs];
  endfunction

  assign fwd_a     = pick(ex_rs1);
  assign fwd_b     = pick(ex_rs2);
  assign rf_rdata1 = rd_port(dec_rs1);
  assign rf_rdata2 = rd_port(dec_rs2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_rs1 <= '0; ex_rs2 <= '0; ex_rd <= '0;
      ex_we  <= 1'b0; ex_ld <= 1'b0; ex_st <= 1'b0;
      mem_rd <= '0; mem_we <= 1'b0;
      wb_rd  <= '0; wb_we  <= 1'b0;
      br_cnt <= '0;
    end else begin
      if (take) begin
        ex_rs1 <= dec_rs1; ex_rs2 <= dec_rs2; ex_rd <= dec_rd;
        ex_we  <= dec_regwrite; ex_ld <= dec_load; ex_st <= dec_store;
      end else begin
        ex_rs1 <= '0; ex_rs2 <= '0; ex_rd <= '0;
        ex_we  <= 1'b0; ex_ld <= 1'b0; ex_st <= 1'b0;
      end
      mem_rd <= ex_rd;  mem_we <= ex_we;
      wb_rd  <= mem_rd; wb_we  <= mem_we;
      if (take && dec_branch)  br_cnt <= CW'(BR_STALL);
      else if (br_cnt != '0)   br_cnt <= br_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (rf_wr) begin
      regs[wb_rd] <= wb_result;
    end
  end
endmodule

module pipe_hazard_ctrl_chk #(
  parameter int RW       = 5,
  parameter int BR_STALL = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_fd,
  input logic          bubble_ex,
  input logic          fetch_hold,
  input logic          ex_regwrite,
  input logic          ex_memwrite,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic [RW-1:0] ex_rs1,
  input logic [RW-1:0] ex_rs2
);
  logic [31:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)          run <= '0;
    else if (fetch_hold) run <= run + 32'd1;
    else                 run <= '0;
  end

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |=> !stall_fd);  // R5
  AST_STALL_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |-> bubble_ex);  // R5
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |=> (!ex_regwrite && !ex_memwrite));  // R6
  AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (fwd_a == 2'b00));  // R4
  AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs2 == '0) |-> (fwd_b == 2'b00));  // R4
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold |-> (run < BR_STALL));  // R8
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_hold) |-> (run == BR_STALL));  // R8
  AST_HOLD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold |-> !stall_fd);  // R8
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.RW(RW), .BR_STALL(BR_STALL)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_fd(stall_fd), .bubble_ex(bubble_ex),
  .fetch_hold(fetch_hold), .ex_regwrite(ex_regwrite), .ex_memwrite(ex_memwrite),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2)
);

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid, dec_regwrite, dec_load, dec_store, dec_branch;
  logic [4:0] dec_rs1, dec_rs2, dec_rd;
  logic [31:0] wb_result;
  logic [1:0] fwd_a, fwd_b;
  logic stall_fd, bubble_ex, fetch_hold, ex_regwrite, ex_memwrite;
  logic [31:0] rf_rdata1, rf_rdata2;

  always #2 clk = ~clk;

  pipe_hazard_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_rs1(dec_rs1),
    .dec_rs2(dec_rs2), .dec_rd(dec_rd), .dec_regwrite(dec_regwrite),
    .dec_load(dec_load), .dec_store(dec_store), .dec_branch(dec_branch),
    .wb_result(wb_result), .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_fd(stall_fd),
    .bubble_ex(bubble_ex), .fetch_hold(fetch_hold), .ex_regwrite(ex_regwrite),
    .ex_memwrite(ex_memwrite), .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2)
  );

  typedef struct packed {
    logic v; logic [4:0] rs1; logic [4:0] rs2; logic [4:0] rd;
    logic we; logic ld; logic st; logic br; logic [31:0] wd;
    logic [1:0] fa; logic [1:0] fb; logic stl; logic hld;
    logic xwe; logic xst; logic [31:0] rd1;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd0,  5'd0,  5'd5,  1'b1,1'b0,1'b0,1'b0, 32'h0,         2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 32'h0},
    '{1'b1, 5'd5,  5'd6,  5'd7,  1'b1,1'b0,1'b0,1'b0, 32'h0,         2'b00,2'b00,1'b0,1'b0,1'b1,1'b0, 32'h0},
    '{1'b1, 5'd5,  5'd7,  5'd8,  1'b1,1'b0,1'b0,1'b0, 32'h0,         2'b10,2'b00,1'b0,1'b0,1'b1,1'b0, 32'h0},
    '{1'b1, 5'd5,  5'd8,  5'd0,  1'b1,1'b0,1'b0,1'b0, 32'h1111_0005, 2'b01,2'b10,1'b0,1'b0,1'b1,1'b0, 32'h1111_0005},
    '{1'b1, 5'd0,  5'd0,  5'd9,  1'b1,1'b1,1'b0,1'b0, 32'h2222_0007, 2'b00,2'b10,1'b0,1'b0,1'b1,1'b0, 32'h0},
    '{1'b1, 5'd9,  5'd0,  5'd10, 1'b1,1'b0,1'b0,1'b0, 32'h3333_0008, 2'b00,2'b00,1'b1,1'b0,1'b1,1'b0, 32'h0},
    '{1'b1, 5'd9,  5'd0,  5'd10, 1'b1,1'b0,1'b0,1'b0, 32'h0000_DEAD, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 32'h0},
    '{1'b1, 5'd9,  5'd10, 5'd11, 1'b1,1'b0,1'b1,1'b0, 32'h4444_0009, 2'b01,2'b00,1'b0,1'b0,1'b1,1'b0, 32'h4444_0009},
    '{1'b1, 5'd9,  5'd11, 5'd0,  1'b0,1'b0,1'b0,1'b1, 32'h0,         2'b00,2'b10,1'b0,1'b0,1'b1,1'b1, 32'h4444_0009},
    '{1'b1, 5'd9,  5'd0,  5'd12, 1'b1,1'b0,1'b0,1'b0, 32'h5555_000A, 2'b00,2'b10,1'b0,1'b1,1'b0,1'b0, 32'h4444_0009},
    '{1'b1, 5'd0,  5'd12, 5'd0,  1'b0,1'b0,1'b1,1'b0, 32'h6666_000B, 2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 32'h0},
    '{1'b1, 5'd12, 5'd12, 5'd13, 1'b1,1'b0,1'b0,1'b0, 32'h0,         2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 32'h0},
    '{1'b1, 5'd12, 5'd13, 5'd14, 1'b1,1'b0,1'b0,1'b0, 32'h0,         2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 32'h0},
    '{1'b1, 5'd14, 5'd14, 5'd14, 1'b1,1'b0,1'b0,1'b0, 32'h0,         2'b00,2'b00,1'b0,1'b0,1'b1,1'b0, 32'h0},
    '{1'b1, 5'd14, 5'd0,  5'd15, 1'b1,1'b0,1'b0,1'b0, 32'h0,         2'b10,2'b10,1'b0,1'b0,1'b1,1'b0, 32'h0},
    '{1'b0, 5'd14, 5'd0,  5'd0,  1'b0,1'b0,1'b0,1'b0, 32'h7777_000E, 2'b10,2'b00,1'b0,1'b0,1'b1,1'b0, 32'h7777_000E},
    '{1'b0, 5'd14, 5'd0,  5'd0,  1'b0,1'b0,1'b0,1'b0, 32'h8888_000E, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 32'h8888_000E},
    '{1'b0, 5'd14, 5'd0,  5'd0,  1'b0,1'b0,1'b0,1'b0, 32'h9999_000F, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 32'h8888_000E}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] d, input logic we, input logic ld,
                       input logic st, input logic br, input logic [31:0] wd);
    dec_valid = v; dec_rs1 = a; dec_rs2 = b; dec_rd = d;
    dec_regwrite = we; dec_load = ld; dec_store = st; dec_branch = br;
    wb_result = wd;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R9 reset state
    chk("R9 stall", {31'b0, stall_fd}, 32'h0);
    chk("R9 hold", {31'b0, fetch_hold}, 32'h0);
    chk("R9 bubble", {31'b0, bubble_ex}, 32'h0);
    chk("R9 exwe", {31'b0, ex_regwrite}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].v, VEC[i].rs1, VEC[i].rs2, VEC[i].rd, VEC[i].we,
            VEC[i].ld, VEC[i].st, VEC[i].br, VEC[i].wd);
      #1;
      chk($sformatf("R1 R2 R3 fwd_a vec %0d", i), {30'b0, fwd_a}, {30'b0, VEC[i].fa});
      chk($sformatf("R1 R2 R3 fwd_b vec %0d", i), {30'b0, fwd_b}, {30'b0, VEC[i].fb});
      chk($sformatf("R5 stall vec %0d", i), {31'b0, stall_fd}, {31'b0, VEC[i].stl});
      chk($sformatf("R8 hold vec %0d", i), {31'b0, fetch_hold}, {31'b0, VEC[i].hld});
      chk($sformatf("R5 R8 bubble vec %0d", i), {31'b0, bubble_ex},
          {31'b0, VEC[i].stl | VEC[i].hld});
      chk($sformatf("R6 exwe vec %0d", i), {31'b0, ex_regwrite}, {31'b0, VEC[i].xwe});
      chk($sformatf("R6 exst vec %0d", i), {31'b0, ex_memwrite}, {31'b0, VEC[i].xst});
      chk($sformatf("R7 R10 rdata1 vec %0d", i), rf_rdata1, VEC[i].rd1);
    end

    // R5 load-use on second source, R6 bubble, R2 forward afterwards
    @(negedge clk); drive(1'b1, 5'd0, 5'd0, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0); #1;
    chk("R5 no stall before consumer", {31'b0, stall_fd}, 32'h0);
    @(negedge clk); drive(1'b1, 5'd0, 5'd3, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0); #1;
    chk("R5 stall on rs2", {31'b0, stall_fd}, 32'h1);
    chk("R5 bubble on rs2", {31'b0, bubble_ex}, 32'h1);
    @(negedge clk); #1;
    chk("R5 stall lasts one cycle", {31'b0, stall_fd}, 32'h0);
    chk("R6 bubble regwrite", {31'b0, ex_regwrite}, 32'h0);
    chk("R6 bubble memwrite", {31'b0, ex_memwrite}, 32'h0);
    @(negedge clk); drive(1'b0, 5'd0, 5'd3, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hABCD_0003); #1;
    chk("R2 load result from writeback", {30'b0, fwd_b}, 32'h1);
    chk("R6 consumer store reaches execute", {31'b0, ex_memwrite}, 32'h1);
    chk("R7 bypass on rs2", rf_rdata2, 32'hABCD_0003);

    // R4 load to register 0 never stalls
    @(negedge clk); drive(1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0); #1;
    @(negedge clk); drive(1'b1, 5'd0, 5'd0, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0); #1;
    chk("R4 no stall on r0 load", {31'b0, stall_fd}, 32'h0);
    @(negedge clk); drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0); #1;
    chk("R4 r0 source not forwarded", {30'b0, fwd_a}, 32'h0);

    // R9 reset mid-run clears registers and slots
    @(negedge clk); rst_n = 1'b0;
    drive(1'b0, 5'd14, 5'd9, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    @(negedge clk); @(negedge clk); rst_n = 1'b1; #1;
    chk("R9 regfile cleared rs1", rf_rdata1, 32'h0);
    chk("R9 regfile cleared rs2", rf_rdata2, 32'h0);
    chk("R9 hold clear", {31'b0, fetch_hold}, 32'h0);
    chk("R9 execute empty", {31'b0, ex_regwrite | ex_memwrite}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule